// File: doc/BRIEF.md
# Serial Command Port for a Four-Channel Output Controller

This block is the slave side of a full-duplex serial link that controls four output channels. When chip select goes low, a status byte supplied by a neighbouring block is loaded into an 8-bit shift register. That byte is then shifted out most significant bit first, while command bits arrive on the data input. When chip select is released, the last eight received bits are committed as a command, but only if the number of serial clock pulses in the select window was a nonzero multiple of eight. Windows of any other length are dropped.

A committed command carries an enable bit, a two-bit channel address and five payload bits. The payload sets one channel's gate request, two-bit blank-time select and off-state fault mask, and it can issue a one-cycle fault-clear pulse to that channel. Serial clock, chip select and data input are brought into the system clock domain through synchronisers, and their edges are detected there. The shift register acts as an eight-stage delay line, so several devices can share one chip select in a chain: each device sends its own status during the first eight clocks and keeps the final eight bits it sees.

Top module: `spi_cmd_port`

## Requirements
- R1: While reset is asserted, and right after it, every gate request, mask, blank-time field and clear pulse is 0 and the data-output enable is 0.
- R2: After chip select falls, the status byte appears on sdo most significant bit first. Bit 7 is valid before the first rising serial clock, and each following bit is valid after each falling serial clock. sdoOe is 1 while selected.
- R3: A committed frame with bit 5 = 1 updates the channel whose number is bits 7:6 (00 = channel 0 up to 11 = channel 3). Bit 0 is written to gateReq[ch], bits 2:1 to blankSel[2ch+1:2ch], and bit 4 to offMask[ch]. Data in is sampled on rising serial clock edges, first bit received becomes bit 7.
- R4: A committed frame with bit 5 = 0 changes no output.
- R5: A select window whose serial clock count is zero or not a multiple of eight changes no output.
- R6: With sixteen clocks in one window, the committed command is the last eight bits received, and bits 9 to 16 on sdo repeat the first eight bits received.
- R7: Bit 3 of an enabled frame produces clrPulse[ch] for exactly one system clock on the addressed channel only. It is never held.
- R8: While chip select is high, sdoOe is 0, and serial clock and data activity change no output.
- R9: A commit alters the fields of the addressed channel only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| statusByte | input | 8 | Status byte loaded at select |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the sdo pad driver |
| gateReq | output | 4 | Per-channel gate request |
| blankSel | output | 8 | Per-channel two-bit blank-time select |
| offMask | output | 4 | Per-channel off-state fault mask |
| clrPulse | output | 4 | Per-channel one-cycle fault-clear pulse |

## Verification
A bit counter that drifts or misses a reset shows up as a dropped valid frame or an accepted odd-length frame. This is visible on the channel fields a few system clocks after chip select rises. A shift register that is loaded or advanced at the wrong point corrupts sdo within the same frame, either in the status bits or in the chained bits of a sixteen-clock window. A decode error in the address or enable path changes the wrong channel or sends a clear pulse to it. That is caught in the cycle after the commit by the one-channel and one-cycle properties.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // Strobes sent from the control side to the datapath, one cycle each
  typedef struct packed {
    logic load;      // chip select fell: parallel-load status
    logic shiftIn;   // rising serial clock while selected
    logic shiftOut;  // falling serial clock while selected
    logic commit;    // release with a valid frame length
    logic selected;  // synchronised chip select is active
  } spi_strobe_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        sdi,
  output logic        sdiSync,
  output spi_strobe_t strb
);
  localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, sdiPipe;
  logic sclkPrev, csPrev;
  logic sclkS, csS;
  logic sclkRise, sclkFall, csFall, csRise;
  logic [CNT_W-1:0] bitCnt;
  logic sawClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdiPipe  <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign sclkS   = sclkPipe[SYNC_STAGES-1];
  assign csS     = csPipe[SYNC_STAGES-1];
  assign sdiSync = sdiPipe[SYNC_STAGES-1];

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;

  // Frame length tracking: modulo counter plus a seen-any-clock flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      sawClk <= 1'b0;
    end else if (csFall) begin
      bitCnt <= '0;
      sawClk <= 1'b0;
    end else if (sclkRise && !csS) begin
      sawClk <= 1'b1;
      if (bitCnt == CNT_W'(FRAME_BITS - 1)) bitCnt <= '0;
      else                                  bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.selected = ~csS;
    strb.load     = csFall;
    strb.shiftIn  = sclkRise & ~csS & ~csFall;
    strb.shiftOut = sclkFall & ~csS & ~csFall;
    strb.commit   = csRise & sawClk & (bitCnt == '0);
  end
endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spi_strobe_t           strb,
  input  logic                  sdiSync,
  input  logic [FRAME_BITS-1:0] statusByte,
  output logic                  sdoBit,
  output logic                  sdoOe,
  output logic [NUM_CH-1:0]     gateReq,
  output logic [2*NUM_CH-1:0]   blankSel,
  output logic [NUM_CH-1:0]     offMask,
  output logic [NUM_CH-1:0]     clrPulse
);
  localparam int ADDR_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int MSB       = FRAME_BITS - 1;
  localparam int GATE_BIT  = 0;
  localparam int BLANK_LSB = 1;
  localparam int CLR_BIT   = 3;
  localparam int MASK_BIT  = 4;
  localparam int EN_BIT    = 5;
  localparam int ADDR_LSB  = FRAME_BITS - ADDR_W;

  logic [FRAME_BITS-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      sdoBit <= 1'b0;
      sdoOe  <= 1'b0;
    end else begin
      sdoOe <= strb.selected;
      if (strb.load) begin
        shReg  <= statusByte;
        sdoBit <= statusByte[MSB];
      end else if (strb.shiftIn) begin
        shReg <= {shReg[MSB-1:0], sdiSync};
      end else if (strb.shiftOut) begin
        sdoBit <= shReg[MSB];
      end
    end
  end

  logic frameOn;
  assign frameOn = strb.commit & shReg[EN_BIT];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hit, gateR, maskR, clrR;
    logic [1:0] blankR;
    assign hit = frameOn & (shReg[ADDR_LSB +: ADDR_W] == ADDR_W'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gateR  <= 1'b0;
        maskR  <= 1'b0;
        blankR <= 2'b00;
        clrR   <= 1'b0;
      end else begin
        clrR <= hit & shReg[CLR_BIT];
        if (hit) begin
          gateR  <= shReg[GATE_BIT];
          maskR  <= shReg[MASK_BIT];
          blankR <= shReg[BLANK_LSB +: 2];
        end
      end
    end

    assign gateReq[ch]       = gateR;
    assign offMask[ch]       = maskR;
    assign blankSel[2*ch +: 2] = blankR;
    assign clrPulse[ch]      = clrR;
  end
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic [FRAME_BITS-1:0] statusByte,
  output logic                  sdo,
  output logic                  sdoOe,
  output logic [NUM_CH-1:0]     gateReq,
  output logic [2*NUM_CH-1:0]   blankSel,
  output logic [NUM_CH-1:0]     offMask,
  output logic [NUM_CH-1:0]     clrPulse
);
  spi_strobe_t strb;
  logic sdiSync;

  spi_cmd_ctrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .sdiSync(sdiSync), .strb(strb)
  );

  spi_cmd_dp #(.NUM_CH(NUM_CH), .FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiSync(sdiSync),
    .statusByte(statusByte), .sdoBit(sdo), .sdoOe(sdoOe),
    .gateReq(gateReq), .blankSel(blankSel), .offMask(offMask),
    .clrPulse(clrPulse)
  );
endmodule

// File: rtl/spi_cmd_port_chk.sv
module spi_cmd_port_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                sdoOe,
  input logic [NUM_CH-1:0]   gateReq,
  input logic [2*NUM_CH-1:0] blankSel,
  input logic [NUM_CH-1:0]   offMask,
  input logic [NUM_CH-1:0]   clrPulse
);
  logic [2:0] csLowCnt, csHighCnt;
  logic [NUM_CH-1:0]   prevGate, prevMask;
  logic [2*NUM_CH-1:0] prevBlank;
  logic [NUM_CH-1:0]   chChanged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLowCnt  <= '0;
      csHighCnt <= '0;
      prevGate  <= '0;
      prevMask  <= '0;
      prevBlank <= '0;
    end else begin
      csLowCnt  <= csN ? 3'd0 : ((csLowCnt == 3'd7) ? csLowCnt : csLowCnt + 3'd1);
      csHighCnt <= !csN ? 3'd0 : ((csHighCnt == 3'd7) ? csHighCnt : csHighCnt + 3'd1);
      prevGate  <= gateReq;
      prevMask  <= offMask;
      prevBlank <= blankSel;
    end
  end

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++)
      chChanged[ch] = (gateReq[ch] != prevGate[ch]) || (offMask[ch] != prevMask[ch]) ||
                      (blankSel[2*ch +: 2] != prevBlank[2*ch +: 2]);
  end

  // R1: outputs held at zero while reset is low
  always @(posedge clk) begin
    if (!rstN)
      a_r1_reset_zero: assert (gateReq == '0 && offMask == '0 && blankSel == '0 &&
                               clrPulse == '0 && !sdoOe);
  end

  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrPulse));

  a_r7_clr_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (clrPulse != '0) |=> (clrPulse == '0));

  a_r9_one_channel: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chChanged) <= 1);

  a_r5_hold_while_selected: assert property (@(posedge clk) disable iff (!rstN)
    (csLowCnt >= 3'd4) |-> ($stable(gateReq) && $stable(offMask) &&
                            $stable(blankSel) && clrPulse == '0));

  a_r2_oe_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    (csLowCnt >= 3'd4) |-> sdoOe);

  a_r8_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csHighCnt >= 3'd4) |-> !sdoOe);
endmodule

bind spi_cmd_port spi_cmd_port_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOe(sdoOe), .gateReq(gateReq),
  .blankSel(blankSel), .offMask(offMask), .clrPulse(clrPulse)
);

// File: tb/spi_cmd_port_bench.sv
module spi_cmd_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, csN, sclk, sdi, sdo, sdoOe;
  logic [7:0] statusByte;
  logic [3:0] gateReq, offMask, clrPulse;
  logic [7:0] blankSel;

  spi_cmd_port u_spi_cmd_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .statusByte(statusByte), .sdo(sdo), .sdoOe(sdoOe), .gateReq(gateReq),
    .blankSel(blankSel), .offMask(offMask), .clrPulse(clrPulse)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int clrCnt [4];

  always @(posedge clk)
    for (int ch = 0; ch < 4; ch++)
      if (clrPulse[ch] === 1'b1) clrCnt[ch]++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Frame: bits taken from mosi[15] downward; sdo captured into miso likewise
  task automatic spiFrame(input int nbits, input logic [15:0] mosi,
                          input logic [7:0] status, output logic [15:0] miso,
                          output logic oeSeen);
    miso = '0;
    oeSeen = 1'b0;
    statusByte = status;
    @(negedge clk); csN = 1'b0;
    repeat (8) @(negedge clk);
    oeSeen = sdoOe;
    for (int i = 0; i < nbits; i++) begin
      sdi = mosi[15-i];
      repeat (6) @(negedge clk);
      miso[15-i] = sdo;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  typedef struct packed {
    logic [4:0]  nbits;
    logic [15:0] mosi;
    logic [7:0]  status;
    logic [3:0]  gate;
    logic [3:0]  mask;
    logic [7:0]  blank;
    logic [3:0]  clr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  16'h2300, 8'hA5, 4'b0001, 4'b0000, 8'h01, 4'b0000},
    '{5'd8,  16'hB600, 8'h3C, 4'b0001, 4'b0100, 8'h31, 4'b0000},
    '{5'd8,  16'hDF00, 8'h81, 4'b0001, 4'b0100, 8'h31, 4'b0000},
    '{5'd5,  16'hF800, 8'h00, 4'b0001, 4'b0100, 8'h31, 4'b0000},
    '{5'd12, 16'hFFF0, 8'h7E, 4'b0001, 4'b0100, 8'h31, 4'b0000},
    '{5'd16, 16'h5A61, 8'hC3, 4'b0011, 4'b0100, 8'h31, 4'b0000},
    '{5'd8,  16'hA800, 8'h96, 4'b0011, 4'b0000, 8'h01, 4'b0100},
    '{5'd8,  16'hF500, 8'h0F, 4'b1011, 4'b1000, 8'h81, 4'b0000},
    '{5'd0,  16'h0000, 8'h55, 4'b1011, 4'b1000, 8'h81, 4'b0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] miso;
    logic oe;
    logic [3:0] g0, m0, c0;
    logic [7:0] b0;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; statusByte = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(gateReq == 0 && offMask == 0 && blankSel == 0 && clrPulse == 0 && !sdoOe,
        "R1", "reset outputs", {gateReq, offMask, blankSel, clrPulse, 7'b0, sdoOe}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(gateReq == 0 && offMask == 0 && blankSel == 0 && !sdoOe,
        "R1", "after reset release", {gateReq, offMask, blankSel, 7'b0, sdoOe}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      string tag;
      int nb, ml;
      logic [15:0] m;
      logic clrOk;
      t = VECS[v];
      nb = int'(t.nbits);
      if (nb == 0 || nb % 8 != 0) tag = "R5";
      else if (nb == 16)          tag = "R6";
      else if (t.mosi[13] == 1'b0) tag = "R4";
      else if (t.clr != 0)        tag = "R7";
      else                        tag = "R3 R9";
      for (int ch = 0; ch < 4; ch++) clrCnt[ch] = 0;
      spiFrame(nb, t.mosi, t.status, miso, oe);
      chk(gateReq == t.gate && offMask == t.mask && blankSel == t.blank, tag,
          "channel fields", {gateReq, offMask, blankSel}, {t.gate, t.mask, t.blank});
      clrOk = 1'b1;
      for (int ch = 0; ch < 4; ch++)
        if (clrCnt[ch] != int'(t.clr[ch])) clrOk = 1'b0;
      chk(clrOk && clrPulse == 0, "R7", "clear pulse cycles per channel",
          {clrCnt[3][7:0], clrCnt[2][7:0], clrCnt[1][7:0], clrCnt[0][7:0]}, {28'b0, t.clr});
      // R2: status byte shifted out MSB first; output enabled while selected
      ml = (nb > 8) ? 8 : nb;
      m = ~(16'hFFFF >> ml);
      chk((miso & m) == ({t.status, 8'h00} & m), "R2", "status on sdo",
          miso & m, {t.status, 8'h00} & m);
      chk(oe == 1'b1, "R2", "sdoOe while selected", oe, 1);
      if (nb == 16)
        chk(miso[7:0] == t.mosi[15:8], "R6", "chained bits on sdo", miso[7:0], t.mosi[15:8]);
    end

    // R8: activity with chip select high is ignored
    g0 = gateReq; m0 = offMask; b0 = blankSel;
    for (int c = 0; c < 4; c++) clrCnt[c] = 0;
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    c0 = {clrCnt[3] != 0, clrCnt[2] != 0, clrCnt[1] != 0, clrCnt[0] != 0};
    chk(gateReq == g0 && offMask == m0 && blankSel == b0 && c0 == 0, "R8",
        "outputs while deselected", {gateReq, offMask, blankSel, c0}, {g0, m0, b0, 4'b0});
    chk(sdoOe == 1'b0, "R8", "sdoOe while deselected", sdoOe, 0);
    sdi = 1'b0;

    // R1: reset pulse mid-run clears all command fields
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(gateReq == 0 && offMask == 0 && blankSel == 0 && !sdoOe, "R1",
        "reset pulse clears", {gateReq, offMask, blankSel, 7'b0, sdoOe}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3: channel 0 back on after reset, blank 10, mask 1
    spiFrame(8, 16'h3500, 8'h00, miso, oe);
    chk(gateReq == 4'b0001 && offMask == 4'b0001 && blankSel == 8'h02, "R3",
        "post-reset command", {gateReq, offMask, blankSel}, {4'b0001, 4'b0001, 8'h02});

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule